// File: doc/BRIEF.md
# Manchester Sensor Frame Transmitter

This block sends a short sensor message over one serial line for a low-rate radio link. The host places a payload of 4-bit values on a parallel input and requests a transmission. An internal periodic timer can also start one. When the request is accepted, the payload is copied into internal registers. Each nibble is then widened to a byte by duplicating every bit, and that byte is line-coded by XNOR with an alternating pattern. The result is a self-clocking Manchester symbol stream.

A frame starts with four alternating preamble bytes and one sync byte, sent unmodified. The encoded payload bytes follow, first nibble first. All bytes leave least significant bit first. Each bit is held for one period of an external bit-rate strobe. The whole frame is sent twice, with a silent interval timed in system clock cycles between the two copies. A busy flag covers the transfer, and a single-cycle done pulse marks its end.

Top module: `sensorFrameTx`

## Requirements
- R1: Payload nibble n (bits [4n+3:4n] of the payload input) is widened to a byte in which nibble bit i occupies byte bits 2i and 2i+1 (0xE widens to 0xFC).
- R2: The widened byte is transmitted as the complement of (widened XOR 0xAA) (0xFC is sent as 0xA9).
- R3: Bytes are serialized least significant bit first. The line changes only on a clock edge where the bit strobe is high, so each bit lasts exactly one strobe period.
- R4: Each copy is 4 bytes of 0xAA, then one byte of 0x99, then the encoded bytes of nibbles 0 to NIBBLES-1 in ascending order.
- R5: The frame is sent twice and the two copies are identical. Between them the line stays low for more than GAP_CYCLES clock cycles and for at most GAP_CYCLES plus one strobe period, because the second copy begins on the first strobe after the gap timer expires.
- R6: An accepted start puts the first preamble bit on the line at the first strobe edge after acceptance, and busy rises on that same edge.
- R7: Busy stays high, through the gap, until the strobe edge that ends the last bit of the second copy. On that edge busy falls and done is high for exactly one cycle. Done is never high at any other time.
- R8: The line is low whenever busy is low.
- R9: A start request, or a timer trigger, that arrives while a transmission is armed or in progress is dropped. It does not start a further transmission after done.
- R10: The payload is captured on the cycle the start is accepted. Later changes on the payload input do not alter either copy of that frame.
- R11: The periodic trigger fires every PERIOD_CYCLES clock cycles, counted from reset release. When it fires while the block is idle, it starts a transmission exactly as a start request does.
- R12: During reset the line, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Bit-rate strobe, one cycle wide |
| startReq | input | 1 | Request to send the payload twice |
| payloadIn | input | 4*NIBBLES | Payload nibbles, nibble 0 in bits [3:0] |
| lineOut | output | 1 | Serial Manchester-coded data line |
| busy | output | 1 | High from the first bit to the end of the second copy |
| done | output | 1 | One-cycle pulse when the second copy ends |

## Verification
An accepted start shows up only at the next strobe edge: that edge raises busy and drives preamble bit 0. Every later bit, the gap's first low level, and the busy fall together with done all land on strobe edges too. The monitor samples at the falling clock edge, so it sees the value each rising edge produced. It records the line once for each cycle that follows a strobe edge. It then compares the stored stream with a frame model once busy falls, and checks done on that cycle and again one cycle later. For the periodic trigger, busy is expected to rise between 1 and one strobe period of edges after each multiple of PERIOD_CYCLES. Consecutive timer-started frames are expected exactly PERIOD_CYCLES apart.

// File: rtl/sensorTxPkg.sv
package sensorTxPkg;

  localparam logic [7:0] PREAMBLE_BYTE  = 8'hAA;
  localparam logic [7:0] SYNC_BYTE      = 8'h99;
  localparam logic [7:0] LINE_MASK      = 8'hAA;
  localparam int         PREAMBLE_COUNT = 4;
  localparam int         HEADER_BYTES   = PREAMBLE_COUNT + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND,
    ST_GAP
  } txState_t;

  // strobes from the sequencer to the serializer
  typedef struct packed {
    logic capture;    // copy payload input into holding registers
    logic startCopy;  // put bit 0 of byte 0 on the line
    logic advance;    // move to the next bit
    logic stopLine;   // force line low after the final bit
  } txStrobes_t;

endpackage

// File: rtl/nibbleEncoder.sv
module nibbleEncoder
  import sensorTxPkg::*;
(
  input  logic [3:0] nibble,
  output logic [7:0] code
);

  logic [7:0] widened;

  generate
    for (genvar i = 0; i < 4; i++) begin : gDouble
      assign widened[2*i]   = nibble[i];
      assign widened[2*i+1] = nibble[i];
    end
  endgenerate

  assign code = ~(widened ^ LINE_MASK);

endmodule

// File: rtl/frameDatapath.sv
module frameDatapath
  import sensorTxPkg::*;
#(
  parameter int NIBBLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobes_t         strobes,
  input  logic [4*NIBBLES-1:0] payloadIn,
  output logic               lineOut,
  output logic               lastBit
);

  localparam int FRAME_BYTES = HEADER_BYTES + NIBBLES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic [4*NIBBLES-1:0] payReg;
  logic [7:0]           encBytes   [NIBBLES];
  logic [7:0]           frameBytes [FRAME_BYTES];
  logic [IDX_W-1:0]     byteIdx;
  logic [2:0]           bitIdx;
  logic [IDX_W-1:0]     nextByte;
  logic [IDX_W-1:0]     safeByte;
  logic [2:0]           nextBit;
  logic                 lineReg;

  generate
    for (genvar n = 0; n < NIBBLES; n++) begin : gEnc
      nibbleEncoder encI (
        .nibble(payReg[4*n +: 4]),
        .code  (encBytes[n])
      );
    end
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : gFrame
      if (k < PREAMBLE_COUNT) begin : gPre
        assign frameBytes[k] = PREAMBLE_BYTE;
      end else if (k == PREAMBLE_COUNT) begin : gSync
        assign frameBytes[k] = SYNC_BYTE;
      end else begin : gPay
        assign frameBytes[k] = encBytes[k - HEADER_BYTES];
      end
    end
  endgenerate

  always_comb begin
    if (bitIdx == 3'd7) begin
      nextByte = byteIdx + 1'b1;
      nextBit  = 3'd0;
    end else begin
      nextByte = byteIdx;
      nextBit  = bitIdx + 1'b1;
    end
    safeByte = (nextByte > LAST_IDX) ? '0 : nextByte;
  end

  assign lastBit = (byteIdx == LAST_IDX) && (bitIdx == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payReg  <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
      lineReg <= 1'b0;
    end else begin
      if (strobes.capture) payReg <= payloadIn;
      if (strobes.startCopy) begin
        byteIdx <= '0;
        bitIdx  <= '0;
        lineReg <= frameBytes[0][0];
      end else if (strobes.advance) begin
        byteIdx <= safeByte;
        bitIdx  <= nextBit;
        lineReg <= frameBytes[safeByte][nextBit];
      end else if (strobes.stopLine) begin
        lineReg <= 1'b0;
      end
    end
  end

  assign lineOut = lineReg;

  // byte pointer never leaves the frame (R4)
  assert_index_range_R4 : assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= LAST_IDX);

  // payload holding registers only change on a capture strobe (R10)
  assert_hold_payload_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(payReg) |-> $past(strobes.capture));

endmodule

// File: rtl/txControl.sv
module txControl
  import sensorTxPkg::*;
#(
  parameter int GAP_CYCLES    = 31200,
  parameter int PERIOD_CYCLES = 133333333
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       bitTick,
  input  logic       lastBit,
  output txStrobes_t strobes,
  output logic       busy,
  output logic       done
);

  localparam int PER_W = $clog2(PERIOD_CYCLES);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CYCLES - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  txState_t         state;
  logic             copyIdx;
  logic [GAP_W-1:0] gapCnt;
  logic [PER_W-1:0] periodCnt;
  logic             fire;
  logic             busyReg;
  logic             doneReg;

  assign fire = (periodCnt == PER_LAST);

  always_comb begin
    strobes.capture   = (state == ST_IDLE) && (startReq || fire);
    strobes.startCopy = (state == ST_ARM) && bitTick;
    strobes.advance   = (state == ST_SEND) && bitTick && !lastBit;
    strobes.stopLine  = (state == ST_SEND) && bitTick && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      copyIdx   <= 1'b0;
      gapCnt    <= '0;
      periodCnt <= '0;
      busyReg   <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg   <= 1'b0;
      periodCnt <= fire ? '0 : periodCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (startReq || fire) begin
            state   <= ST_ARM;
            copyIdx <= 1'b0;
          end
        end
        ST_ARM: begin
          if (bitTick) begin
            state   <= ST_SEND;
            busyReg <= 1'b1;
          end
        end
        ST_SEND: begin
          if (bitTick && lastBit) begin
            if (!copyIdx) begin
              state   <= ST_GAP;
              copyIdx <= 1'b1;
              gapCnt  <= '0;
            end else begin
              state   <= ST_IDLE;
              busyReg <= 1'b0;
              doneReg <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_LAST) state <= ST_ARM;
          else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = busyReg;
  assign done = doneReg;

  // completion pulse only once busy has dropped (R7)
  assert_done_idle_R7 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // completion pulse lasts one cycle (R7)
  assert_done_pulse_R7 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // busy only rises on a strobe edge (R6)
  assert_busy_on_strobe_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(bitTick));

  // a request during a transfer does not re-arm the sequencer (R9)
  assert_ignore_busy_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) && !bitTick |=> state == ST_SEND);

endmodule

// File: rtl/sensorFrameTx.sv
module sensorFrameTx
  import sensorTxPkg::*;
#(
  parameter int NIBBLES       = 4,
  parameter int GAP_CYCLES    = 31200,
  parameter int PERIOD_CYCLES = 133333333
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 startReq,
  input  logic [4*NIBBLES-1:0] payloadIn,
  output logic                 lineOut,
  output logic                 busy,
  output logic                 done
);

  txStrobes_t strobes;
  logic       lastBit;

  txControl #(
    .GAP_CYCLES   (GAP_CYCLES),
    .PERIOD_CYCLES(PERIOD_CYCLES)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .bitTick (bitTick),
    .lastBit (lastBit),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  frameDatapath #(
    .NIBBLES(NIBBLES)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .payloadIn(payloadIn),
    .lineOut  (lineOut),
    .lastBit  (lastBit)
  );

  // line is quiet whenever no transfer is active (R8)
  assert_idle_low_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOut);

  // line moves only on strobe edges (R3)
  assert_line_on_strobe_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineOut) |-> $past(bitTick));

endmodule

// File: tb/sensorFrameTx_tb_top.sv
module sensorFrameTx_tb_top;

  localparam int NIB = 4;
  localparam int GAP = 40;
  localparam int PER = 4000;
  localparam int FL  = (5 + NIB) * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic startReq = 1'b0;
  logic [4*NIB-1:0] payload = 16'h04CE;
  logic lineOut, busy, done;

  always #2 clk = ~clk;

  sensorFrameTx #(.NIBBLES(NIB), .GAP_CYCLES(GAP), .PERIOD_CYCLES(PER)) dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
    .payloadIn(payload), .lineOut(lineOut), .busy(busy), .done(done));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int div = 4;
  int tickCnt = 0;
  logic tickSeen = 1'b0;

  always @(posedge clk) begin
    if (rstN) cyc <= cyc + 1;
    tickSeen <= bitTick;
  end

  always @(negedge clk) begin
    tickCnt = (tickCnt + 1 >= div) ? 0 : tickCnt + 1;
    bitTick = (tickCnt == 0);
  end

  function automatic logic [7:0] expandN(input logic [3:0] n);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i] = n[i];
      r[2*i+1] = n[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] frameByte(input logic [4*NIB-1:0] p, input int k);
    if (k < 4) return 8'hAA;
    if (k == 4) return 8'h99;
    return ~(expandN(p[(k-5)*4 +: 4]) ^ 8'hAA);
  endfunction

  function automatic logic frameBit(input logic [4*NIB-1:0] p, input int i);
    logic [7:0] b;
    b = frameByte(p, i / 8);
    return b[i % 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  logic bitBuf [0:1023];
  int nb = 0;
  logic prevBusy = 1'b0;
  logic prevLine = 1'b0;
  logic pendDone = 1'b0;
  logic payMoved = 1'b0;
  logic [4*NIB-1:0] idlePay = '0;
  logic [4*NIB-1:0] expPay = '0;
  int frameDiv = 1;

  task automatic evalFrame();
    int g;
    bit hdrOk, payOk, gapOk, cpyOk;
    g = nb - 2 * FL;
    chk(g > 0, "R5", "gap strobe count", g, 1);
    if (g <= 0) return;
    hdrOk = 1; payOk = 1; gapOk = 1; cpyOk = 1;
    for (int i = 0; i < 40; i++) if (bitBuf[i] !== frameBit(expPay, i)) hdrOk = 0;
    for (int i = 40; i < FL; i++) if (bitBuf[i] !== frameBit(expPay, i)) payOk = 0;
    for (int i = 0; i < g; i++) if (bitBuf[FL+i] !== 1'b0) gapOk = 0;
    for (int i = 0; i < FL; i++) if (bitBuf[FL+g+i] !== frameBit(expPay, i)) cpyOk = 0;
    chk(hdrOk, "R4", "preamble and sync, LSB first (R3)", hdrOk, 1);
    chk(payOk, "R2", "encoded payload bytes (R1)", payOk, 1);
    chk(gapOk, "R5", "line low in gap", gapOk, 1);
    chk(cpyOk, "R5", "second copy equals first", cpyOk, 1);
    chk((g * frameDiv > GAP) && (g * frameDiv <= GAP + frameDiv), "R5",
        "gap length in cycles", g * frameDiv, GAP + 1);
    if (payMoved) chk(payOk && cpyOk, "R10", "frame after payload change", payOk && cpyOk, 1);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!busy) chk(lineOut == 1'b0, "R8", "line while idle", lineOut, 0);
      if (lineOut != prevLine) chk(tickSeen, "R3", "line change without strobe", tickSeen, 1);
      if (pendDone) begin
        chk(done == 1'b0, "R7", "done pulse width", done, 0);
        pendDone = 1'b0;
      end
      if (busy && !prevBusy) begin
        chk(tickSeen, "R6", "busy rise on strobe edge", tickSeen, 1);
        expPay = idlePay;
        frameDiv = div;
        nb = 0;
        payMoved = 1'b0;
      end
      if (busy && payload != expPay) payMoved = 1'b1;
      if (busy && tickSeen && nb < 1024) begin
        bitBuf[nb] = lineOut;
        nb++;
      end
      if (!busy && prevBusy) begin
        chk(done == 1'b1, "R7", "done at busy fall", done, 1);
        pendDone = 1'b1;
        evalFrame();
      end else if (done && !pendDone) begin
        chk(1'b0, "R7", "done without busy fall", done, 0);
      end
      if (!busy) idlePay = payload;
      prevBusy = busy;
      prevLine = lineOut;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic runFrame(input logic [4*NIB-1:0] nextPay, input int nextDiv, input bit poke);
    int t;
    bit sawBusy;
    int w;
    do step(); while (busy);
    div = nextDiv;
    repeat ($urandom_range(1, 6)) step();
    startReq = 1'b1;
    step();
    startReq = 1'b0;
    t = 0;
    while (!busy && t < 100) begin
      step();
      t++;
    end
    chk(busy, "R6", "frame started after request", busy, 1);
    payload = nextPay;
    if (poke) begin
      repeat ($urandom_range(2, 60)) step();
      startReq = 1'b1;
      step();
      startReq = 1'b0;
    end
    while (busy) step();
    if (poke) begin
      w = 3 * div + 3;
      if ((cyc % PER) + w + 5 < PER) begin
        sawBusy = 0;
        repeat (w) begin
          step();
          if (busy) sawBusy = 1;
        end
        chk(!sawBusy, "R9", "request during transfer was dropped", sawBusy, 0);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int r1, r2, t;
    void'($urandom(32'd1234));
    repeat (5) step();
    chk(lineOut == 1'b0, "R12", "line in reset", lineOut, 0);
    chk(busy == 1'b0, "R12", "busy in reset", busy, 0);
    chk(done == 1'b0, "R12", "done in reset", done, 0);
    rstN = 1'b1;
    // directed corners: first frame carries nibble 0xE -> 0xA9 (R1, R2)
    runFrame(16'h0000, 4, 1'b0);
    runFrame(16'hFFFF, 1, 1'b1);
    runFrame(16'hEC40, 3, 1'b1);
    runFrame(16'hA5A5, 2, 1'b0);
    for (int i = 0; i < 20; i++) begin
      runFrame(16'($urandom()), $urandom_range(1, 4), 1'($urandom_range(0, 1)));
    end
    // periodic trigger (R11)
    div = 4;
    while (busy) step();
    t = 0;
    while (!busy && t < 9000) begin step(); t++; end
    r1 = cyc;
    chk(busy && (r1 % PER) >= 1 && (r1 % PER) <= 4, "R11", "timer start phase", r1 % PER, 1);
    while (busy) step();
    t = 0;
    while (!busy && t < 9000) begin step(); t++; end
    r2 = cyc;
    chk(busy && (r2 - r1 == PER), "R11", "timer period", r2 - r1, PER);
    while (busy) step();
    repeat (5) step();
    summary();
  end

endmodule